// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner among N requesters each cycle. It keeps the relative order of every pair of requesters as one state bit. Only the upper triangle of the pairwise precedence matrix is stored, so N·(N−1)/2 flops hold the whole order. The grant is a combinational function of the present request vector and the stored order. A requester wins when it is asking and no other active requester is ahead of it.

When the caller accepts a grant by raising the update input in the same cycle, the stored order changes at the next clock edge. The winner moves behind every other requester, and the order among the rest is kept. The result is true least-recently-served ordering rather than a rotating pointer. The default build has four requesters.

Top module: `lrs_matrix_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A grant bit is high only if the matching request bit is high. An all-zero request vector yields an all-zero grant.
- R3: After reset, a lower index outranks every higher index. With all requests high, bit 0 is granted. With requests {2,3}, bit 2 is granted.
- R4: The granted requester is the active requester that no other active requester outranks in the current order.
- R5: An accepted grant (`upd_i` high and `gnt_i` nonzero) moves the winner to the lowest priority at the next clock edge. The relative order of all other requesters is unchanged.
- R6: With `upd_i` low, or with no active request, the stored order does not change.
- R7: A requester that keeps requesting is granted within NUM_REQ accepted grants. At most NUM_REQ−1 grants go to others before it wins.
- R8: The grant follows `req_i` in the same cycle. The order change from an accepted grant first shows in the next cycle's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_REQ | Request vector, bit k for requester k |
| upd_i | input | 1 | Accept: commit the present grant into the order |
| gnt_o | output | NUM_REQ | One-hot or zero grant vector |

## Verification
The assertions check these properties on every cycle:
- the grant is one-hot or zero and is a subset of the request;
- an idle cycle or a cycle without accept leaves the stored pair bits untouched;
- after an accepted grant, each pair bit that involves the winner points away from it, and each pair bit between two non-winners holds its value;
- a counter bounds how many accepted grants go to others while a requester waits.

Whether the winner is the right one follows from the whole history of grants. Only the bench's scenarios can show this, by replaying each history against an independent ordered-list model. The same applies to the reset ordering and to whether a mid-run reset restores it.

// File: rtl/lrs_arb_pkg.sv
// Package: shared helpers for the least-recently-served matrix arbiter.
// Assumes requester indices i < j < n.
package lrs_arb_pkg;

    // Flat position of pair (i,j), i<j, inside the packed upper triangle.
    function automatic int unsigned pair_idx(input int unsigned i,
                                             input int unsigned j,
                                             input int unsigned n);
        return i * n - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/lrs_prio_matrix.sv
// Module: lrs_prio_matrix
// Holds one state bit per requester pair (i<j). A set bit means i outranks j.
// Drives the full precedence relation prec_o[a*N+b] = "a outranks b".
// On an accepted grant, the winner is placed below all others.
// Assumes gnt_i is one-hot or zero.
module lrs_prio_matrix #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_i,
    input  logic [NUM_REQ-1:0]         gnt_i,
    output logic [NUM_REQ*NUM_REQ-1:0] prec_o
);
    import lrs_arb_pkg::*;

    localparam int unsigned PAIRS = NUM_REQ * (NUM_REQ - 1) / 2;

    logic [PAIRS-1:0] pair_q;
    logic [PAIRS-1:0] pair_nxt;
    logic             accept;

    assign accept = upd_i && (|gnt_i);

    // Next order: every pair bit that involves the winner points away from it.
    always_comb begin
        pair_nxt = pair_q;
        if (accept) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                for (int j = i + 1; j < NUM_REQ; j++) begin
                    if (gnt_i[i]) begin
                        pair_nxt[pair_idx(i, j, NUM_REQ)] = 1'b0;
                    end else if (gnt_i[j]) begin
                        pair_nxt[pair_idx(i, j, NUM_REQ)] = 1'b1;
                    end
                end
            end
        end
    end

    // Order register: reset makes lower indices win, otherwise load the next order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '1;
        end else begin
            pair_q <= pair_nxt;
        end
    end

    // Expand the triangle into the full relation; the lower half is the complement.
    for (genvar a = 0; a < NUM_REQ; a++) begin : g_row
        for (genvar b = 0; b < NUM_REQ; b++) begin : g_col
            if (a < b) begin : g_up
                assign prec_o[a*NUM_REQ+b] = pair_q[pair_idx(a, b, NUM_REQ)];
            end else if (a > b) begin : g_lo
                assign prec_o[a*NUM_REQ+b] = ~pair_q[pair_idx(b, a, NUM_REQ)];
            end else begin : g_diag
                assign prec_o[a*NUM_REQ+b] = 1'b0;
            end
        end
    end

    AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(pair_q)); // R6

    for (genvar p = 0; p < NUM_REQ; p++) begin : g_chk_i
        for (genvar q = p + 1; q < NUM_REQ; q++) begin : g_chk_j
            localparam int unsigned IDX = pair_idx(p, q, NUM_REQ);
            AST_LOW_WINNER_DEMOTED: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_i && gnt_i[p]) |=> !pair_q[IDX]); // R5
            AST_HIGH_WINNER_DEMOTED: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_i && gnt_i[q]) |=> pair_q[IDX]); // R5
            AST_BYSTANDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!gnt_i[p] && !gnt_i[q]) |=> $stable(pair_q[IDX])); // R5
        end
    end

endmodule

// File: rtl/lrs_grant_pick.sv
// Module: lrs_grant_pick
// Combinational winner selection. A requester wins when it requests
// and no other active requester outranks it. Assumes prec_o from
// lrs_prio_matrix is a strict total order. clk and rst_n serve the checks only.
module lrs_grant_pick #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req_i,
    input  logic [NUM_REQ*NUM_REQ-1:0] prec_i,
    output logic [NUM_REQ-1:0]         gnt_o
);
    logic [NUM_REQ-1:0] blocked;

    // Mark each requester that some active requester outranks, then grant the rest.
    always_comb begin
        blocked = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            for (int j = 0; j < NUM_REQ; j++) begin
                if (j != i && req_i[j] && prec_i[j*NUM_REQ+i]) begin
                    blocked[i] = 1'b1;
                end
            end
        end
        gnt_o = req_i & ~blocked;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R1
    AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0); // R2
    AST_ACTIVE_GETS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> $countones(gnt_o) == 1); // R4

endmodule

// File: rtl/lrs_matrix_arbiter.sv
// Module: lrs_matrix_arbiter (top)
// N-input least-recently-served arbiter. The grant is combinational from
// req_i. Raising upd_i with a nonzero grant commits it at the next edge.
// Assumes NUM_REQ >= 2.
module lrs_matrix_arbiter #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               upd_i,
    output logic [NUM_REQ-1:0] gnt_o
);
    localparam int unsigned CNT_W = $clog2(NUM_REQ + 1);

    logic [NUM_REQ*NUM_REQ-1:0] prec;
    logic [NUM_REQ-1:0]         gnt;

    lrs_prio_matrix #(.NUM_REQ(NUM_REQ)) u_matrix (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (upd_i),
        .gnt_i  (gnt),
        .prec_o (prec)
    );

    lrs_grant_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .prec_i (prec),
        .gnt_o  (gnt)
    );

    assign gnt_o = gnt;

    // Fairness checker: per requester, count accepted grants to others while it waits.
    for (genvar k = 0; k < NUM_REQ; k++) begin : g_wait
        logic [CNT_W-1:0] wait_cnt;

        // Wait counter: clears when idle or served, counts rival wins, saturates.
        always_ff @(posedge clk) begin
            if (!rst_n || !req_i[k] || (upd_i && gnt[k])) begin
                wait_cnt <= '0;
            end else if (upd_i && (|gnt) && wait_cnt != CNT_W'(NUM_REQ)) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end

        AST_NO_STARVATION: assert property (@(posedge clk) disable iff (!rst_n)
            wait_cnt < CNT_W'(NUM_REQ)); // R7
    end

endmodule

// File: tb/lrs_matrix_arbiter_tb.sv
`timescale 1ns/1ps
module lrs_matrix_arbiter_tb;
    localparam int NREQ = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req = '0;
    logic            upd = 1'b0;
    logic [NREQ-1:0] gnt;

    int n_chk  = 0;
    int n_fail = 0;
    int ord  [NREQ];
    int waitc[NREQ];

    always #2 clk = ~clk;

    lrs_matrix_arbiter #(.NUM_REQ(NREQ)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .upd_i (upd),
        .gnt_o (gnt)
    );

    // Model: ordered list, front has the highest priority.
    function automatic void model_reset();
        for (int k = 0; k < NREQ; k++) begin
            ord[k]   = k;
            waitc[k] = 0;
        end
    endfunction

    function automatic logic [NREQ-1:0] model_pick(input logic [NREQ-1:0] r);
        for (int p = 0; p < NREQ; p++) begin
            if (r[ord[p]]) return NREQ'(1) << ord[p];
        end
        return '0;
    endfunction

    function automatic void model_demote(input int w);
        int pos = 0;
        for (int p = 0; p < NREQ; p++) if (ord[p] == w) pos = p;
        for (int p = pos; p < NREQ - 1; p++) ord[p] = ord[p+1];
        ord[NREQ-1] = w;
    endfunction

    task automatic check(input string tag, input logic [NREQ-1:0] act,
                         input logic [NREQ-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check the grant, then follow the edge in the model.
    task automatic step(input logic [NREQ-1:0] r, input logic u, input string tag);
        logic [NREQ-1:0] exp;
        @(negedge clk);
        req = r;
        upd = u;
        #1;
        exp = model_pick(r);
        check(tag, gnt, exp);
        @(posedge clk);
        if (u && exp != '0) begin
            for (int k = 0; k < NREQ; k++) begin
                if (exp[k]) begin
                    model_demote(k);
                    waitc[k] = 0;
                end else if (r[k]) begin
                    waitc[k]++;
                end else begin
                    waitc[k] = 0;
                end
            end
        end else begin
            for (int k = 0; k < NREQ; k++) if (!r[k]) waitc[k] = 0;
        end
        n_chk++;
        for (int k = 0; k < NREQ; k++) begin
            if (waitc[k] > NREQ - 1) begin
                n_fail++;
                $display("FAIL R7: requester %0d waited=%0d expected<=%0d",
                         k, waitc[k], NREQ - 1);
                waitc[k] = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        upd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R3: reset order, lowest index first.
        step(4'b1111, 1'b0, "R3");
        check("R3", gnt, 4'b0001);
        step(4'b1100, 1'b0, "R3");
        check("R3", gnt, 4'b0100);
        // R2: no request means no grant.
        step(4'b0000, 1'b0, "R2");
        check("R2", gnt, 4'b0000);
        // R6: without accept, the order holds.
        step(4'b1111, 1'b0, "R6");
        step(4'b1111, 1'b0, "R6");
        check("R6", gnt, 4'b0001);
        // R6: accept with an idle request vector changes nothing.
        step(4'b0000, 1'b1, "R6");
        step(4'b1111, 1'b0, "R6");
        check("R6", gnt, 4'b0001);
        // R5/R8: accepted grants rotate the full set, each visible next cycle.
        step(4'b1111, 1'b1, "R5");
        check("R8", gnt, 4'b0001);
        step(4'b1111, 1'b1, "R5");
        check("R8", gnt, 4'b0010);
        step(4'b1111, 1'b1, "R5");
        check("R8", gnt, 4'b0100);
        step(4'b1111, 1'b1, "R5");
        check("R5", gnt, 4'b1000);
        // R4: least-recently-served differs from a rotating pointer.
        // The order is now 0,1,2,3. Serving 2 gives 0,1,3,2, then serving 0 gives 1,3,2,0.
        step(4'b0100, 1'b1, "R4");
        step(4'b0001, 1'b1, "R4");
        step(4'b1101, 1'b0, "R4");
        check("R4", gnt, 4'b1000);
        step(4'b0101, 1'b0, "R4");
        check("R4", gnt, 4'b0100);

        // R1/R4/R5/R7: random traffic against the model.
        for (int c = 0; c < 4000; c++) begin
            logic [NREQ-1:0] r;
            r = NREQ'($urandom);
            if (($urandom % 3) == 0) r = r | NREQ'($urandom);
            step(r, ($urandom % 4) != 0, "R4");
        end

        // R3: a reset mid-run restores the initial order.
        do_reset();
        step(4'b1010, 1'b0, "R3");
        check("R3", gnt, 4'b0010);

        // R7: requester 3 held high while the others compete.
        for (int c = 0; c < 40; c++) begin
            step(4'b1000 | NREQ'($urandom), 1'b1, "R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule